// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the arithmetic and logic stage of an 8-bit accumulator processor. Each cycle it may accept one opcode with the current accumulator, a second operand that earlier logic has already resolved from a register or from memory, and the current flag byte. One cycle later it presents the new accumulator value, the new flag byte, and a write-enable that tells the register file whether the accumulator should be updated.

Two instruction groups are decoded. Opcodes shaped `10 ooo rrr` select one of eight two-operand operations. For these opcodes the unit also reports the 3-bit source field so that the sequencer can check which operand it supplied. Opcodes shaped `00 ooo 111` select one of eight operations on the accumulator alone: rotates, decimal adjust, complement, and the carry-flag operations. Any other opcode leaves the accumulator and the upper flag nibble untouched. The flag byte keeps zero, subtract, half-carry and carry in its upper nibble. The lower nibble of the output is always zero.

Top module: `acc_alu`

## Requirements
- R1: The flag byte holds Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. Bits 3:0 of `flags_out` are always 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_valid` is 0 and `acc_out`, `flags_out`, `acc_we` and `src_sel` keep their values.
- R3: In the `10 ooo rrr` group, ooo=000 (ADD) gives A+operand and ooo=001 (ADC) gives A+operand+C. N is cleared. H is the carry out of bit 3 and C is the carry out of bit 7. Z is set when the 8-bit result is zero.
- R4: ooo=010 (SUB) gives A−operand and ooo=011 (SBC) gives A−operand−C. N is set. H is the borrow into bit 4, C is the borrow out of bit 7, and Z is set from the result.
- R5: ooo=111 (CP) sets all four flags exactly as SUB would. It drives `acc_we` low and returns A unchanged on `acc_out`.
- R6: ooo=100 (AND) sets H and clears N and C. ooo=101 (XOR) and ooo=110 (OR) clear N, H and C. All three set Z when the result is zero.
- R7: In the `00 ooo 111` group, ooo=000 rotates left circularly, 001 rotates right circularly, 010 rotates left through C and 011 rotates right through C. C receives the bit shifted out, and Z, N and H are cleared.
- R8: ooo=100 is decimal adjust. When N=0, it adds 0x60 if C=1 or A>0x99, and adds 0x06 if H=1 or A[3:0]>9. When N=1, it subtracts 0x60 if C=1 and subtracts 0x06 if H=1. C becomes 1 if the high correction was applied, and otherwise keeps its old value. H is cleared, N is kept, and Z is set from the result.
- R9: ooo=101 inverts A and sets N and H. ooo=110 sets C, and ooo=111 inverts C. These last two clear N and H. None of the three changes Z, and ooo=101 keeps C.
- R10: `acc_we` is 1 for ADD, ADC, SUB, SBC, AND, XOR, OR, the four rotates, decimal adjust and complement. It is 0 for CP, set-carry and invert-carry, which return A unchanged on `acc_out`.
- R11: `src_sel` carries opcode bits 2:0 for the two-operand group and 0 for every other opcode.
- R12: Any opcode outside both groups gives `acc_we`=0 and `acc_out`=A. `flags_out` is then the upper nibble of `flags_in` followed by four zero bits.
- R13: While `rst` is high, every output register is cleared to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs on this cycle carry an operation |
| opcode | input | 8 | Instruction byte |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Resolved second operand |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Registered results are new this cycle |
| acc_out | output | 8 | New accumulator value |
| flags_out | output | 8 | New flag byte, low nibble zero |
| acc_we | output | 1 | Accumulator write-enable |
| src_sel | output | 3 | Decoded operand source field |

## Verification
The bound assertions are checked on every cycle. They cover the one-cycle valid latency and the hold on idle cycles, the zero low flag nibble, and the suppressed write and subtract flag of CP. They also cover Z tracking the stored two-operand result, cleared flags after rotates, set-carry flag behaviour, the reported source field and pass-through of unrecognised opcodes. Exact arithmetic values can only be shown by the bench's scenarios. These include half-carry and borrow edges, carry-in of ADC and SBC, both branches of decimal adjust, and the rotate bit paths. The bench also sweeps every opcode of both groups with random operands against its own model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW      = 8;
    localparam int FL_Z    = 7;
    localparam int FL_N    = 6;
    localparam int FL_H    = 5;
    localparam int FL_C    = 4;
    localparam int NIB     = DW / 2;

    typedef enum logic [4:0] {
        OP_NONE, OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_XOR, OP_OR, OP_CP,
        OP_RLC,  OP_RRC, OP_RL,  OP_RR,  OP_DEC, OP_INV, OP_STC, OP_CMC
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] acc;
        flags_t        fl;
        logic          we;
    } alu_res_t;

    function automatic flags_t flags_from_byte(input logic [NIB-1:0] hi);
        flags_t f;
        f.z = hi[FL_Z-NIB];
        f.n = hi[FL_N-NIB];
        f.h = hi[FL_H-NIB];
        f.c = hi[FL_C-NIB];
        return f;
    endfunction

    function automatic logic [DW-1:0] flags_to_byte(input flags_t f);
        logic [DW-1:0] b;
        b       = '0;
        b[FL_Z] = f.z;
        b[FL_N] = f.n;
        b[FL_H] = f.h;
        b[FL_C] = f.c;
        return b;
    endfunction

    function automatic logic is_unary(input alu_op_e op);
        return op inside {OP_RLC, OP_RRC, OP_RL, OP_RR, OP_DEC, OP_INV, OP_STC, OP_CMC};
    endfunction

endpackage

// File: rtl/acc_alu_dec.sv
module acc_alu_dec
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] opcode,
    output alu_op_e       op,
    output logic [2:0]    src
);
    always_comb begin
        op  = OP_NONE;
        src = 3'b000;
        if (opcode[7:6] == 2'b10) begin
            src = opcode[2:0];
            case (opcode[5:3])
                3'd0:    op = OP_ADD;
                3'd1:    op = OP_ADC;
                3'd2:    op = OP_SUB;
                3'd3:    op = OP_SBC;
                3'd4:    op = OP_AND;
                3'd5:    op = OP_XOR;
                3'd6:    op = OP_OR;
                default: op = OP_CP;
            endcase
        end else if (opcode[7:6] == 2'b00 && opcode[2:0] == 3'b111) begin
            case (opcode[5:3])
                3'd0:    op = OP_RLC;
                3'd1:    op = OP_RRC;
                3'd2:    op = OP_RL;
                3'd3:    op = OP_RR;
                3'd4:    op = OP_DEC;
                3'd5:    op = OP_INV;
                3'd6:    op = OP_STC;
                default: op = OP_CMC;
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_binop.sv
module acc_alu_binop
    import acc_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  flags_t        fi,
    output alu_res_t      res
);
    logic          cin;
    logic          sub;
    logic [NIB:0]  lo;
    logic [DW:0]   full;
    logic [DW-1:0] lres;

    always_comb begin
        cin = (op == OP_ADC || op == OP_SBC) ? fi.c : 1'b0;
        sub = (op == OP_SUB || op == OP_SBC || op == OP_CP);
        if (sub) begin
            lo   = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
            full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
        end else begin
            lo   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
            full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        end

        case (op)
            OP_AND:  lres = a & b;
            OP_XOR:  lres = a ^ b;
            default: lres = a | b;
        endcase

        res.acc = a;
        res.fl  = fi;
        res.we  = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP: begin
                res.acc  = (op == OP_CP) ? a : full[DW-1:0];
                res.we   = (op != OP_CP);
                res.fl.z = (full[DW-1:0] == '0);
                res.fl.n = sub;
                res.fl.h = lo[NIB];
                res.fl.c = full[DW];
            end
            OP_AND, OP_XOR, OP_OR: begin
                res.acc  = lres;
                res.we   = 1'b1;
                res.fl.z = (lres == '0);
                res.fl.n = 1'b0;
                res.fl.h = (op == OP_AND);
                res.fl.c = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_unop.sv
module acc_alu_unop
    import acc_alu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  flags_t        fi,
    output alu_res_t      res
);
    logic          hi_fix;
    logic          lo_fix;
    logic [DW-1:0] corr;
    logic [DW-1:0] dres;

    always_comb begin
        if (!fi.n) begin
            hi_fix = fi.c || (a > 8'h99);
            lo_fix = fi.h || (a[NIB-1:0] > 4'd9);
        end else begin
            hi_fix = fi.c;
            lo_fix = fi.h;
        end
        corr = (hi_fix ? 8'h60 : 8'h00) | (lo_fix ? 8'h06 : 8'h00);
        dres = fi.n ? (a - corr) : (a + corr);

        res.acc = a;
        res.fl  = fi;
        res.we  = 1'b0;
        case (op)
            OP_RLC, OP_RRC, OP_RL, OP_RR: begin
                res.we   = 1'b1;
                res.fl.z = 1'b0;
                res.fl.n = 1'b0;
                res.fl.h = 1'b0;
                case (op)
                    OP_RLC:  begin res.acc = {a[DW-2:0], a[DW-1]}; res.fl.c = a[DW-1]; end
                    OP_RRC:  begin res.acc = {a[0], a[DW-1:1]};    res.fl.c = a[0];    end
                    OP_RL:   begin res.acc = {a[DW-2:0], fi.c};    res.fl.c = a[DW-1]; end
                    default: begin res.acc = {fi.c, a[DW-1:1]};    res.fl.c = a[0];    end
                endcase
            end
            OP_DEC: begin
                res.acc  = dres;
                res.we   = 1'b1;
                res.fl.z = (dres == '0);
                res.fl.h = 1'b0;
                res.fl.c = hi_fix;
            end
            OP_INV: begin
                res.acc  = ~a;
                res.we   = 1'b1;
                res.fl.n = 1'b1;
                res.fl.h = 1'b1;
            end
            OP_STC, OP_CMC: begin
                res.fl.n = 1'b0;
                res.fl.h = 1'b0;
                res.fl.c = (op == OP_STC) ? 1'b1 : ~fi.c;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    opcode,
    input  logic [7:0]    acc_in,
    input  logic [7:0]    opnd_in,
    input  logic [7:0]    flags_in,
    output logic          out_valid,
    output logic [7:0]    acc_out,
    output logic [7:0]    flags_out,
    output logic          acc_we,
    output logic [2:0]    src_sel
);
    alu_op_e  op;
    logic [2:0] src;
    flags_t   fl_cur;
    alu_res_t bin_res;
    alu_res_t un_res;
    alu_res_t pick;
    logic     unused_low_flags;

    assign fl_cur           = flags_from_byte(flags_in[DW-1:NIB]);
    assign unused_low_flags = ^flags_in[NIB-1:0];

    acc_alu_dec u_dec (
        .opcode (opcode),
        .op     (op),
        .src    (src)
    );

    acc_alu_binop u_bin (
        .op  (op),
        .a   (acc_in),
        .b   (opnd_in),
        .fi  (fl_cur),
        .res (bin_res)
    );

    acc_alu_unop u_un (
        .op  (op),
        .a   (acc_in),
        .fi  (fl_cur),
        .res (un_res)
    );

    assign pick = is_unary(op) ? un_res : bin_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            acc_out   <= '0;
            flags_out <= '0;
            acc_we    <= 1'b0;
            src_sel   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_out   <= pick.acc;
                flags_out <= flags_to_byte(pick.fl);
                acc_we    <= pick.we;
                src_sel   <= src;
            end
        end
    end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] opcode,
    input logic [7:0] acc_in,
    input logic [7:0] flags_in,
    input logic       out_valid,
    input logic [7:0] acc_out,
    input logic [7:0] flags_out,
    input logic       acc_we,
    input logic [2:0] src_sel
);
    logic is_bin, is_acc, is_cp, is_rot, is_stc;

    always_comb begin
        is_bin = (opcode[7:6] == 2'b10);
        is_acc = (opcode[7:6] == 2'b00) && (opcode[2:0] == 3'b111);
        is_cp  = is_bin && (opcode[5:3] == 3'b111);
        is_rot = is_acc && (opcode[5] == 1'b0);
        is_stc = is_acc && (opcode[5:3] == 3'b110);
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(acc_out) && $stable(flags_out) && $stable(src_sel))); // R2
    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags_out[3:0] == 4'h0)); // R1
    AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_cp) |=> (!acc_we && acc_out == $past(acc_in) && flags_out[6])); // R5
    AST_BIN_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_bin && !is_cp) |=> (flags_out[7] == (acc_out == 8'h00))); // R3
    AST_ROT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_rot) |=> (flags_out[7:5] == 3'b000 && acc_we)); // R7
    AST_SET_CARRY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_stc) |=> (flags_out[4] && !flags_out[6] && !flags_out[5]
                                  && flags_out[7] == $past(flags_in[7]) && !acc_we)); // R9
    AST_SRC_FIELD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_bin) |=> (src_sel == $past(opcode[2:0]))); // R11
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_bin && !is_acc) |=> (!acc_we && acc_out == $past(acc_in)
                                              && flags_out[7:4] == $past(flags_in[7:4])
                                              && src_sel == 3'b000)); // R12
endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .acc_in    (acc_in),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .acc_out   (acc_out),
    .flags_out (flags_out),
    .acc_we    (acc_we),
    .src_sel   (src_sel)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic       out_valid;
    logic [7:0] acc_out;
    logic [7:0] flags_out;
    logic       acc_we;
    logic [2:0] src_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
        .out_valid(out_valid), .acc_out(acc_out), .flags_out(flags_out),
        .acc_we(acc_we), .src_sel(src_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent behavioural model: {we, acc, flags}
    function automatic logic [16:0] model(input logic [7:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] f);
        logic z, n, h, c, we;
        logic [7:0] r;
        int t, ci, corr;
        z = f[7]; n = f[6]; h = f[5]; c = f[4]; r = a; we = 1'b0;
        if (op[7:6] == 2'b10) begin
            ci = (op[5:3] == 3'd1 || op[5:3] == 3'd3) ? int'(c) : 0;
            case (op[5:3])
                3'd0, 3'd1: begin
                    t = int'(a) + int'(b) + ci;
                    h = ((int'(a) % 16) + (int'(b) % 16) + ci) > 15;
                    c = t > 255; n = 1'b0; r = t[7:0]; z = (r == 0); we = 1'b1;
                end
                3'd2, 3'd3, 3'd7: begin
                    t = int'(a) - int'(b) - ci;
                    h = ((int'(a) % 16) - (int'(b) % 16) - ci) < 0;
                    c = t < 0; n = 1'b1; z = (t[7:0] == 0);
                    if (op[5:3] != 3'd7) begin r = t[7:0]; we = 1'b1; end
                end
                3'd4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; we = 1; end
                3'd5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; end
                default: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; end
            endcase
        end else if (op[7:6] == 2'b00 && op[2:0] == 3'b111) begin
            case (op[5:3])
                3'd0: begin r = {a[6:0], a[7]}; c = a[7]; z = 0; n = 0; h = 0; we = 1; end
                3'd1: begin r = {a[0], a[7:1]}; c = a[0]; z = 0; n = 0; h = 0; we = 1; end
                3'd2: begin r = {a[6:0], c}; c = a[7]; z = 0; n = 0; h = 0; we = 1; end
                3'd3: begin r = {c, a[7:1]}; c = a[0]; z = 0; n = 0; h = 0; we = 1; end
                3'd4: begin
                    corr = 0;
                    if (!n) begin
                        if (c || a > 8'h99) begin corr += 96; c = 1; end
                        if (h || a[3:0] > 4'd9) corr += 6;
                        t = int'(a) + corr;
                    end else begin
                        if (c) corr += 96;
                        if (h) corr += 6;
                        t = int'(a) - corr;
                    end
                    r = t[7:0]; z = (r == 0); h = 0; we = 1;
                end
                3'd5: begin r = ~a; n = 1; h = 1; we = 1; end
                3'd6: begin c = 1; n = 0; h = 0; end
                default: begin c = ~c; n = 0; h = 0; end
            endcase
        end
        return {we, r, z, n, h, c, 4'b0000};
    endfunction

    // Drive one operation and sample one cycle later at the falling edge
    task automatic apply(input logic [7:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] f);
        @(negedge clk);
        opcode = op; acc_in = a; opnd_in = b; flags_in = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_op(input string req, input logic [7:0] op, input logic [7:0] a,
                             input logic [7:0] b, input logic [7:0] f,
                             input logic [7:0] e_acc, input logic [7:0] e_fl, input logic e_we);
        apply(op, a, b, f);
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " acc"},   32'(acc_out),   32'(e_acc));
        check({req, " flags"}, 32'(flags_out), 32'(e_fl));
        check({req, " we"},    32'(acc_we),    32'(e_we));
    endtask

    task automatic t_reset();
        check("R13 valid", 32'(out_valid), 32'd0);
        check("R13 acc",   32'(acc_out),   32'd0);
        check("R13 flags", 32'(flags_out), 32'd0);
        check("R13 we",    32'(acc_we),    32'd0);
        check("R13 src",   32'(src_sel),   32'd0);
    endtask

    task automatic t_add();
        expect_op("R3 add carry", 8'h80, 8'h3A, 8'hC6, 8'h00, 8'h00, 8'hB0, 1'b1);
        expect_op("R3 adc half",  8'h88, 8'h0F, 8'h00, 8'h10, 8'h10, 8'h20, 1'b1);
        expect_op("R1 add plain", 8'h80, 8'h01, 8'h02, 8'hFF, 8'h03, 8'h00, 1'b1);
    endtask

    task automatic t_sub();
        expect_op("R4 sub zero",  8'h90, 8'h3E, 8'h3E, 8'h00, 8'h00, 8'hC0, 1'b1);
        expect_op("R4 sub half",  8'h90, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h60, 1'b1);
        expect_op("R4 sbc wrap",  8'h98, 8'h00, 8'h00, 8'h10, 8'hFF, 8'h70, 1'b1);
        expect_op("R5 cp borrow", 8'hB8, 8'h10, 8'h20, 8'h00, 8'h10, 8'h50, 1'b0);
        expect_op("R5 cp equal",  8'hBF, 8'h42, 8'h42, 8'h00, 8'h42, 8'hC0, 1'b0);
    endtask

    task automatic t_logic();
        expect_op("R6 and zero", 8'hA0, 8'hF0, 8'h0F, 8'h50, 8'h00, 8'hA0, 1'b1);
        expect_op("R6 xor zero", 8'hA8, 8'hFF, 8'hFF, 8'h70, 8'h00, 8'h80, 1'b1);
        expect_op("R6 or",       8'hB0, 8'h01, 8'h80, 8'hF0, 8'h81, 8'h00, 1'b1);
    endtask

    task automatic t_rotate();
        expect_op("R7 rlca", 8'h07, 8'h85, 8'h00, 8'hE0, 8'h0B, 8'h10, 1'b1);
        expect_op("R7 rrca", 8'h0F, 8'h01, 8'h00, 8'h00, 8'h80, 8'h10, 1'b1);
        expect_op("R7 rla",  8'h17, 8'h80, 8'h00, 8'h80, 8'h00, 8'h10, 1'b1);
        expect_op("R7 rra",  8'h1F, 8'h01, 8'h00, 8'h10, 8'h80, 8'h10, 1'b1);
        expect_op("R7 rla c0", 8'h17, 8'h41, 8'h00, 8'h00, 8'h82, 8'h00, 1'b1);
    endtask

    task automatic t_daa();
        expect_op("R8 daa add low",  8'h27, 8'h3C, 8'h00, 8'h00, 8'h42, 8'h00, 1'b1);
        expect_op("R8 daa add high", 8'h27, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h90, 1'b1);
        expect_op("R8 daa sub",      8'h27, 8'h2D, 8'h00, 8'h60, 8'h27, 8'h40, 1'b1);
        expect_op("R8 daa keep c",   8'h27, 8'h00, 8'h00, 8'h50, 8'hA0, 8'h50, 1'b1);
    endtask

    task automatic t_misc();
        expect_op("R9 cpl",       8'h2F, 8'h35, 8'h00, 8'h90, 8'hCA, 8'hF0, 1'b1);
        expect_op("R10 scf",      8'h37, 8'h35, 8'h00, 8'hE0, 8'h35, 8'h90, 1'b0);
        expect_op("R9 ccf set",   8'h3F, 8'h35, 8'h00, 8'h10, 8'h35, 8'h00, 1'b0);
        expect_op("R9 ccf clear", 8'h3F, 8'h35, 8'h00, 8'h80, 8'h35, 8'h90, 1'b0);
    endtask

    task automatic t_src();
        apply(8'h86, 8'h00, 8'h00, 8'h00);
        check("R11 src bin", 32'(src_sel), 32'd6);
        apply(8'hBD, 8'h00, 8'h00, 8'h00);
        check("R11 src cp", 32'(src_sel), 32'd5);
        apply(8'h2F, 8'h00, 8'h00, 8'h00);
        check("R11 src unary", 32'(src_sel), 32'd0);
    endtask

    task automatic t_unmatched();
        expect_op("R12 nop",   8'h00, 8'h5A, 8'h11, 8'hAF, 8'h5A, 8'hA0, 1'b0);
        expect_op("R12 ld",    8'h47, 8'hC3, 8'h11, 8'h5F, 8'hC3, 8'h50, 1'b0);
        expect_op("R12 other", 8'hFE, 8'h01, 8'h01, 8'h30, 8'h01, 8'h30, 1'b0);
    endtask

    task automatic t_hold();
        apply(8'h80, 8'h12, 8'h34, 8'h00);
        check("R2 first", 32'(acc_out), 32'h46);
        @(negedge clk);
        opcode = 8'hA8; acc_in = 8'hFF; opnd_in = 8'hFF; flags_in = 8'hF0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 idle valid", 32'(out_valid), 32'd0);
            check("R2 idle acc",   32'(acc_out),   32'h46);
            check("R2 idle flags", 32'(flags_out), 32'h00);
        end
    endtask

    task automatic t_sweep();
        logic [16:0] e;
        logic [7:0] op, a, b, f;
        for (int g = 0; g < 16; g++) begin
            for (int k = 0; k < 40; k++) begin
                a = 8'($urandom_range(0, 255));
                b = 8'($urandom_range(0, 255));
                f = 8'($urandom_range(0, 255));
                if (g < 8) op = {2'b10, 3'(g), 3'($urandom_range(0, 7))};
                else       op = {2'b00, 3'(g - 8), 3'b111};
                e = model(op, a, b, f);
                apply(op, a, b, f);
                check(g < 8 ? "R3 R4 R5 R6 sweep" : "R7 R8 R9 R10 sweep",
                      {15'd0, acc_we, acc_out, flags_out}, {15'd0, e});
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_add();
        t_sub();
        t_logic();
        t_rotate();
        t_daa();
        t_misc();
        t_src();
        t_unmatched();
        t_hold();
        t_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule